// File: doc/BRIEF.md
# DMA Burst Sequencer With Bus Release

This block paces the word-wide DMA bus cycles of a communications device after the host has granted it the bus. A pending transfer raises the bus request. Every granted word cycle is opened with a one-clock address strobe, and each cycle is closed by a done handshake from the bus side. Payload traffic for received and transmitted data runs as bursts. The burst length is set by a two-bit configuration: one word, eight words, or open-ended. In the open-ended setting the burst ends when the data source reports empty or when a safety cap is reached. Buffer-management traffic, such as descriptor, status and initialisation accesses, always runs as a single word per request.

The host can cut a burst short through an active-low release input, which works only while a release-enable input is high. The release is sampled on the clock edge that launches a word's strobe. When it is seen there, that word is marked as the last one, and the request drops once that word's done arrives. A release that becomes active after a launch edge has no effect on the word already running. It takes effect on the next word only if it is still active at that word's launch edge. Every transfer is a full word, so the block has no byte-select outputs.

Top module: `dmab_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, `bus_req_o`, `strobe_o`, `cyc_o` and `last_o` are all low.
- R2: With the block idle, a high `xfer_req_i` sampled on a clock edge raises `bus_req_o` in the following cycle. `bus_req_o` then stays high until the burst ends.
- R3: A word cycle launches on a clock edge where the bus is granted (`grant_i` high). `strobe_o` is high for exactly the one cycle after that edge, and `cyc_o` stays high until that word's `cyc_done_i` is sampled.
- R4: With `xfer_data_i` = 0 (buffer-management access), exactly one word cycle runs, whatever `burst_cfg_i` holds.
- R5: With `xfer_data_i` = 1, `burst_cfg_i` = 2'b00 gives a burst of 1 word and `burst_cfg_i` = 2'b01 gives a burst of 8 words.
- R6: With `burst_cfg_i` = 2'b10 or 2'b11 (open-ended), the word whose launch edge samples `src_empty_i` high is the last one. If the source never reports empty, the burst stops after 33 words.
- R7: When `rel_en_i` is high and `rel_n_i` is low at a word's launch edge, that word is the last one. `last_o` is high from its strobe cycle until its done.
- R8: A release that goes active only after a launch edge does not shorten the word in progress. If it is held to the next launch edge, the next word is the last one. If it is gone again by then, the burst runs to its configured length.
- R9: While `rel_en_i` is low, `rel_n_i` has no effect on burst length.
- R10: After `cyc_done_i` is sampled during a word flagged by `last_o`, `bus_req_o` is low in the following cycle.
- R11: If `grant_i` is low when a non-last word completes, no new strobe is issued until `grant_i` returns. `bus_req_o` stays high during the wait, and the burst's word count continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req_i | input | 1 | A transfer is pending; sampled while idle |
| xfer_data_i | input | 1 | 1 = payload burst, 0 = buffer-management single word |
| burst_cfg_i | input | 2 | 00 = 1 word, 01 = 8 words, 1x = open-ended |
| src_empty_i | input | 1 | Data source empty, sampled at each launch edge |
| rel_en_i | input | 1 | Enables the release function |
| rel_n_i | input | 1 | Active-low bus release, sampled at each launch edge |
| grant_i | input | 1 | Bus granted to this device |
| cyc_done_i | input | 1 | Current word cycle has completed |
| bus_req_o | output | 1 | Bus request |
| strobe_o | output | 1 | One-cycle address strobe opening a word cycle |
| cyc_o | output | 1 | A word cycle is in progress |
| last_o | output | 1 | The current word cycle ends the burst |

## Verification
Bursts are run with each length setting and with both transfer types. This separates the one-word and eight-word limits from each other and from the single-word rule for buffer-management accesses. The open-ended setting is run twice: once with the source going empty partway through, and once with the source never going empty, which reaches the cap.

Release is applied in three ways. A release held before a launch edge must shorten the burst at that word. One that starts just after a launch edge must carry over to the next word. A one-cycle pulse between launch edges must leave the burst length unchanged. A release held while the enable is low must change nothing.

A grant withdrawn between words tests that the burst resumes with its count intact rather than restarting.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_CYC  = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      BS_WORD1    = 2'd0,
      BS_WORD8    = 2'd1,
      BS_OPEN     = 2'd2,
      BS_OPEN_ALT = 2'd3
   } burst_cfg_t;

endpackage

// File: rtl/dmab_wcnt.sv
module dmab_wcnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   if (W < 1) begin : g_bad_w
      $error("dmab_wcnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end

endmodule

// File: rtl/dmab_rel_gate.sv
module dmab_rel_gate #(
   parameter int HAS_RELEASE = 1
) (
   input  logic rel_en_i,
   input  logic rel_n_i,
   output logic rel_seen
);

   if (HAS_RELEASE != 0) begin : g_rel
      assign rel_seen = rel_en_i & ~rel_n_i;
   end else begin : g_norel
      logic unused_rel;
      assign unused_rel = rel_en_i ^ rel_n_i;
      assign rel_seen   = 1'b0;
   end

endmodule

// File: rtl/dmab_last_eval.sv
module dmab_last_eval
   import dmab_pkg::*;
#(
   parameter int SHORT_WORDS    = 1,
   parameter int MID_WORDS      = 8,
   parameter int OPEN_CAP_WORDS = 33,
   parameter int CNT_W          = 6
) (
   input  logic [CNT_W-1:0] done_words,
   input  logic             data_xfer,
   input  logic [1:0]       cfg,
   input  logic             src_empty,
   input  logic             rel_seen,
   output logic             end_here
);

   localparam int NW = CNT_W + 1;

   logic [NW-1:0] nth;
   logic          hit_limit;

   assign nth = {1'b0, done_words} + NW'(1);

   always_comb begin
      unique case (burst_cfg_t'(cfg))
         BS_WORD1:             hit_limit = (nth >= NW'(SHORT_WORDS));
         BS_WORD8:             hit_limit = (nth >= NW'(MID_WORDS));
         BS_OPEN, BS_OPEN_ALT: hit_limit = src_empty | (nth >= NW'(OPEN_CAP_WORDS));
         default:              hit_limit = 1'b1;
      endcase
      end_here = ~data_xfer | rel_seen | hit_limit;
   end

endmodule

// File: rtl/dmab_seq.sv
module dmab_seq
   import dmab_pkg::*;
#(
   parameter int SHORT_WORDS    = 1,
   parameter int MID_WORDS      = 8,
   parameter int OPEN_CAP_WORDS = 33,
   parameter int HAS_RELEASE    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_req_i,
   input  logic       xfer_data_i,
   input  logic [1:0] burst_cfg_i,
   input  logic       src_empty_i,
   input  logic       rel_en_i,
   input  logic       rel_n_i,
   input  logic       grant_i,
   input  logic       cyc_done_i,
   output logic       bus_req_o,
   output logic       strobe_o,
   output logic       cyc_o,
   output logic       last_o
);

   localparam int CNT_W = $clog2(OPEN_CAP_WORDS + 1);

   if (SHORT_WORDS < 1) begin : g_bad_short
      $error("dmab_seq: SHORT_WORDS must be at least 1");
   end
   if (MID_WORDS <= SHORT_WORDS) begin : g_bad_mid
      $error("dmab_seq: MID_WORDS must exceed SHORT_WORDS");
   end
   if (OPEN_CAP_WORDS <= MID_WORDS) begin : g_bad_cap
      $error("dmab_seq: OPEN_CAP_WORDS must exceed MID_WORDS");
   end

   seq_st_t          st;
   logic [1:0]       cfg_q;
   logic             data_q;
   logic             strobe_q;
   logic             last_q;
   logic [CNT_W-1:0] words_q;
   logic             rel_seen;
   logic             end_here;
   logic             pick;
   logic             word_end;
   logic             launch;

   // a new request is accepted only from idle
   assign pick     = (st == ST_IDLE) & xfer_req_i;
   assign word_end = (st == ST_CYC) & cyc_done_i;
   // launch edge: first word after grant, or back-to-back word after a non-last done
   assign launch   = grant_i & ((st == ST_REQ) | (word_end & ~last_q));

   dmab_rel_gate #(
      .HAS_RELEASE (HAS_RELEASE)
   ) u_rel (
      .rel_en_i (rel_en_i),
      .rel_n_i  (rel_n_i),
      .rel_seen (rel_seen)
   );

   dmab_wcnt #(
      .W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pick),
      .inc   (launch),
      .count (words_q)
   );

   dmab_last_eval #(
      .SHORT_WORDS    (SHORT_WORDS),
      .MID_WORDS      (MID_WORDS),
      .OPEN_CAP_WORDS (OPEN_CAP_WORDS),
      .CNT_W          (CNT_W)
   ) u_last (
      .done_words (words_q),
      .data_xfer  (data_q),
      .cfg        (cfg_q),
      .src_empty  (src_empty_i),
      .rel_seen   (rel_seen),
      .end_here   (end_here)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cfg_q  <= '0;
         data_q <= 1'b0;
      end else begin
         if (pick) begin
            cfg_q  <= burst_cfg_i;
            data_q <= xfer_data_i;
         end
         unique case (st)
            ST_IDLE: if (xfer_req_i) st <= ST_REQ;
            ST_REQ:  if (grant_i)    st <= ST_CYC;
            ST_CYC: begin
               if (cyc_done_i) begin
                  if (last_q)        st <= ST_IDLE;
                  else if (!grant_i) st <= ST_REQ;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         strobe_q <= launch;
         if (launch)        last_q <= end_here;
         else if (word_end) last_q <= 1'b0;
      end
   end

   assign bus_req_o = (st != ST_IDLE);
   assign strobe_o  = strobe_q;
   assign cyc_o     = (st == ST_CYC);
   assign last_o    = last_q & (st == ST_CYC);

endmodule

// File: rtl/dmab_seq_chk.sv
module dmab_seq_chk #(
   parameter int HAS_RELEASE = 1
) (
   input logic clk,
   input logic rst_n,
   input logic grant_i,
   input logic cyc_done_i,
   input logic rel_en_i,
   input logic rel_n_i,
   input logic bus_req_o,
   input logic strobe_o,
   input logic cyc_o,
   input logic last_o
);

   // R3: a strobe only follows an edge where the bus was granted
   a_r3_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(grant_i));

   // R3: the strobe lasts one cycle unless the word completes at once and the next launches
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && !cyc_done_i) |=> !strobe_o);

   // R3: a strobe only appears inside a requested word cycle
   a_r3_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> (cyc_o && bus_req_o));

   // R10: the request drops right after the last word completes
   a_r10_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_o && last_o && cyc_done_i) |=> !bus_req_o);

   // R2: the request holds until the last word completes
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !(cyc_o && last_o && cyc_done_i)) |=> bus_req_o);

   if (HAS_RELEASE != 0) begin : g_rel_chk
      // R7: a release seen at the launch edge marks that word as last
      a_r7_release_marks_last: assert property (@(posedge clk) disable iff (!rst_n)
         (strobe_o && $past(rel_en_i && !rel_n_i)) |-> last_o);
   end

endmodule

bind dmab_seq dmab_seq_chk #(.HAS_RELEASE(HAS_RELEASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .grant_i    (grant_i),
   .cyc_done_i (cyc_done_i),
   .rel_en_i   (rel_en_i),
   .rel_n_i    (rel_n_i),
   .bus_req_o  (bus_req_o),
   .strobe_o   (strobe_o),
   .cyc_o      (cyc_o),
   .last_o     (last_o)
);

// File: tb/dmab_seq_test.sv
`timescale 1ns/1ps
module dmab_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_req_i = 1'b0;
   logic       xfer_data_i = 1'b0;
   logic [1:0] burst_cfg_i = 2'b00;
   logic       src_empty_i = 1'b0;
   logic       rel_en_i = 1'b0;
   logic       rel_n_i = 1'b1;
   logic       grant_i = 1'b0;
   logic       cyc_done_i = 1'b0;
   logic       bus_req_o, strobe_o, cyc_o, last_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dmab_seq uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_req_i  (xfer_req_i),
      .xfer_data_i (xfer_data_i),
      .burst_cfg_i (burst_cfg_i),
      .src_empty_i (src_empty_i),
      .rel_en_i    (rel_en_i),
      .rel_n_i     (rel_n_i),
      .grant_i     (grant_i),
      .cyc_done_i  (cyc_done_i),
      .bus_req_o   (bus_req_o),
      .strobe_o    (strobe_o),
      .cyc_o       (cyc_o),
      .last_o      (last_o)
   );

   // ---------------- behavioural reference model ----------------
   int m_phase;   // 0 idle, 1 waiting for grant, 2 word in progress
   int m_words;
   bit m_strobe, m_last, m_data;
   int m_cfg;

   function automatic bit ref_ends(int nth);
      if (!m_data) return 1'b1;
      if (rel_en_i && !rel_n_i) return 1'b1;
      if (m_cfg == 0) return nth >= 1;
      if (m_cfg == 1) return nth >= 8;
      return src_empty_i || nth >= 33;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_words = 0; m_strobe = 0; m_last = 0; m_data = 0; m_cfg = 0;
      end else begin
         bit go;
         go = 1'b0;
         m_strobe = 1'b0;
         if (m_phase == 0) begin
            if (xfer_req_i) begin
               m_phase = 1; m_words = 0; m_data = xfer_data_i; m_cfg = int'(burst_cfg_i);
            end
         end else if (m_phase == 1) begin
            go = grant_i;
         end else if (cyc_done_i) begin
            if (m_last) begin
               m_phase = 0; m_last = 0;
            end else if (grant_i) go = 1'b1;
            else m_phase = 1;
         end
         if (go) begin
            m_words++;
            m_last = ref_ends(m_words);
            m_strobe = 1'b1;
            m_phase = 2;
         end
      end
   end

   task automatic cmp(input string tag, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp_int(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cmp("R2", "bus_req_o", bus_req_o, m_phase != 0);
         cmp("R3", "strobe_o", strobe_o, m_strobe);
         cmp("R3", "cyc_o", cyc_o, m_phase == 2);
         cmp("R7", "last_o", last_o, m_last && m_phase == 2);
      end
   end

   // rel_mode: 0 none, 1 held once rel_k words have strobed, 2 one-cycle pulse in word rel_k's strobe cycle
   task automatic run_burst(input string tag, input bit kind, input logic [1:0] cfg,
                            input int empty_at, input int rel_mode, input int rel_k,
                            input bit en, input int gap_k, input int exp_words);
      int ns = 0;
      int gcnt = 0;
      int guard = 0;
      bit drop_pending = 1'b0;
      bit gap_req_ok = 1'b1;
      @(negedge clk);
      xfer_data_i = kind;
      burst_cfg_i = cfg;
      rel_en_i    = en;
      src_empty_i = (empty_at == 1);
      rel_n_i     = !(rel_mode == 1 && rel_k == 0);
      xfer_req_i  = 1'b1;
      @(negedge clk);
      cmp("R2", "bus_req_o one cycle after request", bus_req_o, 1'b1);
      xfer_req_i = 1'b0;
      while (guard < 400) begin
         guard++;
         if (drop_pending) begin
            cmp("R10", "bus_req_o after last done", bus_req_o, 1'b0);
            break;
         end
         if (strobe_o) ns++;
         cyc_done_i = cyc_o && !strobe_o;
         if (cyc_done_i && last_o) drop_pending = 1'b1;
         src_empty_i = (empty_at != 0) && (ns >= empty_at - 1);
         if (rel_mode == 1)      rel_n_i = !(ns >= rel_k);
         else if (rel_mode == 2) rel_n_i = !(ns == rel_k && strobe_o);
         else                    rel_n_i = 1'b1;
         if (gap_k != 0 && ns == gap_k && gcnt < 4 && !strobe_o) begin
            grant_i = 1'b0;
            gcnt++;
            if (gcnt > 1 && !bus_req_o) gap_req_ok = 1'b0;
         end else begin
            grant_i = bus_req_o;
         end
         @(negedge clk);
      end
      cmp_int(tag, "words in burst", ns, exp_words);
      if (gap_k != 0) cmp("R11", "request held through grant gap", gap_req_ok, 1'b1);
      grant_i = 1'b0; cyc_done_i = 1'b0; rel_n_i = 1'b1; src_empty_i = 1'b0; rel_en_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low while in reset
      cmp("R1", "bus_req_o in reset", bus_req_o, 1'b0);
      cmp("R1", "strobe_o in reset", strobe_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1", "cyc_o after reset", cyc_o, 1'b0);
      cmp("R1", "last_o after reset", last_o, 1'b0);

      run_burst("R4", 1'b0, 2'b01, 0, 0, 0, 1'b0, 0, 1);   // R4 management: one word
      run_burst("R5", 1'b1, 2'b00, 0, 0, 0, 1'b0, 0, 1);   // R5 1-word setting
      run_burst("R5", 1'b1, 2'b01, 0, 0, 0, 1'b0, 0, 8);   // R5 8-word setting
      run_burst("R6", 1'b1, 2'b10, 5, 0, 0, 1'b0, 0, 5);   // R6 empty at word 5
      run_burst("R6", 1'b1, 2'b11, 0, 0, 0, 1'b0, 0, 33);  // R6 cap
      run_burst("R7", 1'b1, 2'b01, 0, 1, 2, 1'b1, 0, 3);   // R7 release held before word 3 launch
      run_burst("R7", 1'b1, 2'b10, 0, 1, 0, 1'b1, 0, 1);   // R7 release from the start
      run_burst("R8", 1'b1, 2'b01, 0, 1, 4, 1'b1, 0, 5);   // R8 late release carries to next word
      run_burst("R8", 1'b1, 2'b01, 0, 2, 2, 1'b1, 0, 8);   // R8 pulse between launches ignored
      run_burst("R9", 1'b1, 2'b01, 0, 1, 0, 1'b0, 0, 8);   // R9 release while disabled
      run_burst("R11", 1'b1, 2'b01, 0, 0, 0, 1'b0, 3, 8);  // R11 grant withdrawn after word 3

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule